// File: doc/BRIEF.md
# Vector table address remapper

This unit sits between a processor's memory request port and the system memories. The lowest 64 bytes of the address space hold 16 words: eight exception vector slots, each paired with a literal word that carries a far branch target. A 2-bit mode register selects which physical memory serves accesses to these 64 bytes. The choices are boot ROM, user flash, internal RAM or the external memory bus. Every access above the window goes through untranslated.

The unit also decodes the translated address into a one-hot region select. Software changes the mode with an ordinary bus write to the register address and reads it back with an ordinary bus read. Translation is combinational. The mode register is the only state in the unit.

Top module: `vector_remap`

## Requirements
- R1: An access is in the window when its byte address is 0x00 to 0x3F. Any address at or above 0x40, other than the register address, comes out on `outAddr` unchanged with `outValid` high, whatever the mode.
- R2: After reset the mode is 00. A read (`reqWrite`=0) of address 0xE01FC040 raises `rdValid` in the same cycle and returns the mode in `rdData[1:0]` with bits [31:2] zero. `rdValid` is low on any other access.
- R3: A write to 0xE01FC040 stores `reqWdata[1:0]`, and the new mode applies from the next cycle on. Writes to any other address leave the mode unchanged.
- R4: In mode 00, window address A is translated to 0x7FFFE000 + A[5:0].
- R5: In mode 01, window address A comes out unchanged, because user flash starts at 0x00000000.
- R6: In mode 10, window address A is translated to 0x40000000 + A[5:0].
- R7: In mode 11, window address A is translated to the external base (default 0x80000000) + A[5:0].
- R8: `regionSel` is one-hot whenever `outValid` is high, and it is decoded from `outAddr`:
  - bit 0 is boot ROM, for 0x7FFFE000 to 0x7FFFFFFF.
  - bit 1 is flash, for addresses below 0x40000000.
  - bit 2 is RAM, for 0x40000000 to 0x7FFFDFFF.
  - bit 3 is external, for 0x80000000 and above.
- R9: An access to the register address drives `outValid` low and `regionSel` to zero.
- R10: While `reqValid` is low, `outValid`, `rdValid` and `regionSel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address from the processor |
| reqWdata | input | 32 | Write data |
| outValid | output | 1 | Translated access toward memory |
| outAddr | output | 32 | Translated byte address |
| regionSel | output | 4 | One-hot region: 0 ROM, 1 flash, 2 RAM, 3 external |
| rdValid | output | 1 | Register read data valid |
| rdData | output | 32 | Register readback |

## Verification
The hardest situation to reach is the cycle right after a mode write. In that cycle a window access must already use the new mode, while the write cycle itself produced no memory access. The stimulus does a write and then, in the next cycle, a window access or a register read. It does this for each of the four modes, and it places writes to neighbouring addresses between them to show that those writes do not disturb the mode. The first and last window words, 0x00 and 0x3C, and the first word outside, 0x40, are swept in every mode.

// File: rtl/remap_pkg.sv
`timescale 1ns/1ps
package remap_pkg;
  typedef enum logic [1:0] {
    MODE_BOOT  = 2'b00,
    MODE_FLASH = 2'b01,
    MODE_RAM   = 2'b10,
    MODE_EXT   = 2'b11
  } remapMode_t;

  localparam int REGION_N = 4;
  localparam int IDX_ROM = 0;
  localparam int IDX_FLASH = 1;
  localparam int IDX_RAM = 2;
  localparam int IDX_EXT = 3;

  typedef struct packed {
    remapMode_t mode;
    logic       regHit;
  } ctrlStrobe_t;
endpackage

// File: rtl/remap_ctrl.sv
`timescale 1ns/1ps
module remap_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 32'hE01FC040
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output remap_pkg::ctrlStrobe_t strobe,
  output logic rdValid,
  output logic [DATA_W-1:0] rdData
);
  import remap_pkg::*;

  localparam int MODE_W = 2;

  remapMode_t modeQ;
  logic regHit;
  logic wrHit;

  assign regHit = reqValid && (reqAddr == REG_ADDR);
  assign wrHit = regHit && reqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_BOOT;
    else if (wrHit) modeQ <= remapMode_t'(reqWdata[MODE_W-1:0]);
  end

  always_comb begin
    rdValid = regHit && !reqWrite;
    rdData = '0;
    if (rdValid) rdData[MODE_W-1:0] = modeQ;
  end

  assign strobe.mode = modeQ;
  assign strobe.regHit = regHit;

  a_r3_write_applies: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> (modeQ == $past(reqWdata[MODE_W-1:0])));
  a_r3_mode_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> $stable(modeQ));
  a_r2_rd_only_on_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (reqValid && !reqWrite && rdData[DATA_W-1:MODE_W] == '0));
endmodule

// File: rtl/remap_dp.sv
`timescale 1ns/1ps
module remap_dp #(
  parameter int ADDR_W = 32,
  parameter int WIN_BYTES = 64,
  parameter logic [ADDR_W-1:0] ROM_BASE = 32'h7FFFE000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h40000000,
  parameter logic [ADDR_W-1:0] EXT_BASE = 32'h80000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  remap_pkg::ctrlStrobe_t strobe,
  output logic outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [remap_pkg::REGION_N-1:0] regionSel
);
  import remap_pkg::*;

  localparam int OFS_W = $clog2(WIN_BYTES);

  logic inWindow;
  logic [ADDR_W-1:0] winOfs;
  logic [1:0] regionIdx;

  assign inWindow = (reqAddr[ADDR_W-1:OFS_W] == '0);
  assign winOfs = {{(ADDR_W-OFS_W){1'b0}}, reqAddr[OFS_W-1:0]};
  assign outValid = reqValid && !strobe.regHit;

  always_comb begin
    outAddr = reqAddr;
    if (inWindow) begin
      unique case (strobe.mode)
        MODE_BOOT:  outAddr = ROM_BASE + winOfs;
        MODE_FLASH: outAddr = winOfs;
        MODE_RAM:   outAddr = RAM_BASE + winOfs;
        MODE_EXT:   outAddr = EXT_BASE + winOfs;
        default:    outAddr = reqAddr;
      endcase
    end
  end

  always_comb begin
    if (outAddr >= EXT_BASE) regionIdx = 2'(IDX_EXT);
    else if (outAddr >= ROM_BASE) regionIdx = 2'(IDX_ROM);
    else if (outAddr >= RAM_BASE) regionIdx = 2'(IDX_RAM);
    else regionIdx = 2'(IDX_FLASH);
  end

  for (genvar g = 0; g < REGION_N; g++) begin : gSel
    assign regionSel[g] = outValid && (regionIdx == 2'(g));
  end

  a_r8_onehot: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(regionSel) == 1));
  a_r9_reg_no_sel: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && strobe.regHit) |-> (regionSel == '0 && !outValid));
  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !inWindow) |-> (outAddr == reqAddr));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (regionSel == '0 && !outValid));
endmodule

// File: rtl/vector_remap.sv
`timescale 1ns/1ps
module vector_remap #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_BYTES = 64,
  parameter logic [ADDR_W-1:0] REG_ADDR = 32'hE01FC040,
  parameter logic [ADDR_W-1:0] ROM_BASE = 32'h7FFFE000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h40000000,
  parameter logic [ADDR_W-1:0] EXT_BASE = 32'h80000000
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [3:0] regionSel,
  output logic rdValid,
  output logic [DATA_W-1:0] rdData
);
  remap_pkg::ctrlStrobe_t strobe;

  remap_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .strobe(strobe),
    .rdValid(rdValid), .rdData(rdData)
  );

  remap_dp #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .ROM_BASE(ROM_BASE),
             .RAM_BASE(RAM_BASE), .EXT_BASE(EXT_BASE)) uDp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .strobe(strobe), .outValid(outValid), .outAddr(outAddr),
    .regionSel(regionSel)
  );
endmodule

// File: tb/sim_vector_remap.sv
`timescale 1ns/1ps
module sim_vector_remap;
  localparam logic [31:0] REG_A = 32'hE01FC040;

  typedef struct {
    logic oV;
    logic [31:0] oA;
    logic [3:0] sel;
    logic rV;
    logic [31:0] rD;
    string tag;
  } item_t;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic outValid, rdValid;
  logic [31:0] outAddr, rdData;
  logic [3:0] regionSel;

  int checks = 0, fails = 0;
  logic [1:0] mdl = 2'b00;
  item_t q[$];
  bit done = 0;

  always #4 clk = ~clk;

  vector_remap u0 (.clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .outValid(outValid), .outAddr(outAddr),
    .regionSel(regionSel), .rdValid(rdValid), .rdData(rdData));

  function automatic logic [3:0] regionOf(logic [31:0] a);
    if (a >= 32'h80000000) return 4'b1000;
    if (a >= 32'h7FFFE000) return 4'b0001;
    if (a >= 32'h40000000) return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic drive(input logic v, input logic w, input logic [31:0] a,
                       input logic [31:0] d, input string tag);
    item_t e;
    @(negedge clk);
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d;
    e.tag = tag;
    e.rV = v && !w && (a == REG_A);
    e.rD = e.rV ? {30'b0, mdl} : 32'b0;
    e.oV = v && (a != REG_A);
    if (a < 32'h40) begin
      case (mdl)
        2'b00: e.oA = 32'h7FFFE000 + a;
        2'b01: e.oA = a;
        2'b10: e.oA = 32'h40000000 + a;
        default: e.oA = 32'h80000000 + a;
      endcase
    end else e.oA = a;
    e.sel = e.oV ? regionOf(e.oA) : 4'b0;
    q.push_back(e);
    if (v && w && a == REG_A) mdl = d[1:0];
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (outValid !== e.oV || rdValid !== e.rV || regionSel !== e.sel ||
            (e.oV && outAddr !== e.oA) || rdData !== e.rD) begin
          fails++;
          $display("FAIL %s: got v=%b a=%h sel=%b rv=%b rd=%h exp v=%b a=%h sel=%b rv=%b rd=%h",
            e.tag, outValid, outAddr, regionSel, rdValid, rdData,
            e.oV, e.oA, e.sel, e.rV, e.rD);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    drive(1, 0, REG_A, 0, "R2 reset mode");
    drive(0, 0, 32'h10, 0, "R10 idle");
    for (int m = 0; m < 4; m++) begin
      drive(1, 1, REG_A, 32'hFFFFFFF0 | m, "R9 reg write");
      drive(1, 0, 32'h00, 0, m == 0 ? "R4 first word" : m == 1 ? "R5 first word" :
                                m == 2 ? "R6 first word" : "R7 first word");
      drive(1, 0, 32'h3C, 0, "R4 R5 R6 R7 last word");
      drive(1, 1, 32'h18, 0, "R8 window write");
      drive(1, 0, 32'h40, 0, "R1 first outside");
      drive(1, 0, REG_A, 0, "R2 readback");
      drive(1, 1, REG_A + 4, 32'h3 ^ m, "R3 neighbour write");
      drive(1, 1, REG_A - 4, 32'h2 ^ m, "R3 neighbour write low");
      drive(1, 0, REG_A, 0, "R3 mode held");
      drive(1, 0, 32'h7FFFE010, 0, "R8 rom region");
      drive(1, 0, 32'h40001000, 0, "R8 ram region");
      drive(1, 0, 32'hA0000000, 0, "R8 ext region");
      drive(1, 0, 32'h00001000, 0, "R8 flash region");
      drive(0, 1, REG_A, 32'h0, "R10 idle write ignored");
      drive(1, 0, 32'h24, 0, "R3 idle write no effect");
    end
    drive(1, 1, REG_A, 32'h2, "R3 write");
    drive(1, 0, 32'h3F, 0, "R6 next cycle new mode");
    drive(0, 0, 0, 0, "R10 idle end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule